// File: doc/BRIEF.md
# Dual-Plane Segment Blink Controller

This block keeps two bit planes of segment data for a small multiplexed LED display, one row per digit in each plane. It produces the segment vector for the digit that the scan counter currently selects. A free-running blink timer divides time into a first half and a second half. When blinking is switched on, the pair of bits that a segment holds in the two planes selects one of four behaviours: off, lit in the first half only, lit in the second half only, or lit all the time. When blinking is switched off, only the primary plane is shown.

A one-byte control register is written through a single-cycle write strobe. It switches blinking on or off. Two of its bits are one-shot actions: one restarts the blink timer and the digit scan, and the other wipes both planes. The readback byte carries the live blink half. A clock-enable tick advances both the blink timer and the digit scan.

Top module: `blink_plane_ctrl`

## Requirements
- R1: After synchronous reset, both planes are all zero, blinking is off, the blink timer and the scan counter are zero, and the timer is in the first half. So `seg_o` is 0, `digit_o` is 0 and `cfg_rdata_o` is 8'h80.
- R2: With the enable bit (bit 3) at 0, `seg_o` equals the primary-plane row (`pl_sel_i`=0) of the selected digit, whatever the secondary plane holds.
- R3: With the enable bit at 1, each segment decodes its pair {secondary, primary}: 00 is off, 01 is lit only in the first half, 10 is lit only in the second half, 11 is always lit.
- R4: Each tick advances the blink counter. After HALF_TICKS ticks the half flips. Readback bit 7 reads 1 in the first half and 0 in the second half.
- R5: A control write with bit 4 set zeroes the blink counter, returns the timer to the first half and returns the scan to digit 0 at that clock edge, even if a tick arrives in the same cycle. Bit 4 reads back as 0.
- R6: A control write with bit 5 set zeroes every row of both planes at that edge, and bit 5 reads back as 0. With bit 5 at 0 the planes are left unchanged.
- R7: When a plane write and a clearing control write fall in the same cycle, the clear wins and the written row ends up zero.
- R8: Each tick moves `digit_o` to the next digit, and it wraps from NUM_DIGITS-1 to 0.
- R9: Bits 2 and 0 are stored and read back but do not change `seg_o`. Bits 6 and 1 are not stored and always read 0.
- R10: A plane write stores `pl_wdata_i` in the row at `pl_addr_i` of the primary plane (`pl_sel_i`=0) or the secondary plane (`pl_sel_i`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Clock enable for the blink timer and the digit scan |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control write data |
| cfg_rdata_o | output | 8 | Control readback, with the live blink half in bit 7 |
| pl_we_i | input | 1 | Plane write strobe |
| pl_sel_i | input | 1 | Plane select: 0 primary, 1 secondary |
| pl_addr_i | input | DIG_W | Digit row address |
| pl_wdata_i | input | SEGS | Row data |
| seg_o | output | SEGS | Segment vector of the selected digit |
| digit_o | output | DIG_W | Currently scanned digit |

## Verification
Random rows are written into both planes, and the display is scanned with blinking on and with blinking off, in both halves of the blink period. These cases separate a decoder that mixes in the secondary plane when it should not from one that swaps the two halves. Directed patterns hold every pair value on one segment each, so a fault in any single pair is seen on its own segment. Directed cases also set the secondary plane with blinking off and issue a clear in the same cycle as a plane write. Resync writes are sent together with ticks to show that the restart takes priority over counting.

// File: rtl/blink_pkg.sv
package blink_pkg;

    localparam int CFG_BIT_S     = 0;
    localparam int CFG_BIT_B     = 2;
    localparam int CFG_BIT_EN    = 3;
    localparam int CFG_BIT_SYNC  = 4;
    localparam int CFG_BIT_CLR   = 5;
    localparam int CFG_BIT_PHASE = 7;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic en;
        logic b_bit;
        logic s_bit;
    } cfg_t;

    // Pair decode for one segment: {secondary, primary}
    function automatic logic seg_bit(input logic sec, input logic pri,
                                     input logic en, input phase_e ph);
        logic r;
        if (!en) begin
            r = pri;
        end else begin
            case ({sec, pri})
                2'b00:   r = 1'b0;
                2'b01:   r = (ph == PH_FIRST);
                2'b10:   r = (ph == PH_SECOND);
                default: r = 1'b1;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/blink_timer.sv
module blink_timer
    import blink_pkg::*;
#(
    parameter int HALF_TICKS = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    input  logic   resync_i,
    output phase_e phase_o
);
    localparam int CNT_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    phase_e           phase_q;

    always_ff @(posedge clk) begin
        if (rst || resync_i) begin
            cnt_q   <= '0;
            phase_q <= PH_FIRST;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                cnt_q   <= '0;
                phase_q <= (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase_o = phase_q;

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    p_phase_flip_r4: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !resync_i && cnt_q == LAST) |=> phase_q != $past(phase_q));
    p_phase_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !resync_i) |=> $stable(phase_q) && $stable(cnt_q));
    p_resync_timer_r5: assert property (@(posedge clk) disable iff (rst)
        resync_i |=> (cnt_q == '0 && phase_q == PH_FIRST));
endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
    parameter int NUM_DIGITS = 4,
    parameter int DIG_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             resync_i,
    output logic [DIG_W-1:0] digit_o
);
    localparam logic [DIG_W-1:0] LAST = DIG_W'(NUM_DIGITS - 1);

    logic [DIG_W-1:0] scan_q;

    always_ff @(posedge clk) begin
        if (rst || resync_i) begin
            scan_q <= '0;
        end else if (tick_i) begin
            scan_q <= (scan_q == LAST) ? '0 : scan_q + 1'b1;
        end
    end

    assign digit_o = scan_q;

    p_scan_range_r8: assert property (@(posedge clk) disable iff (rst)
        scan_q <= LAST);
    p_scan_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !resync_i && scan_q == LAST) |=> scan_q == '0);
    p_scan_sync_r5: assert property (@(posedge clk) disable iff (rst)
        resync_i |=> scan_q == '0);
endmodule

// File: rtl/plane_store.sv
module plane_store #(
    parameter int NUM_DIGITS = 4,
    parameter int SEGS       = 8,
    parameter int DIG_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic             sel_i,
    input  logic [DIG_W-1:0] addr_i,
    input  logic [SEGS-1:0]  wdata_i,
    input  logic [DIG_W-1:0] rd_addr_i,
    output logic [SEGS-1:0]  pri_row_o,
    output logic [SEGS-1:0]  sec_row_o
);
    logic [SEGS-1:0] pri_q [NUM_DIGITS];
    logic [SEGS-1:0] sec_q [NUM_DIGITS];
    logic            any_set;

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                pri_q[d] <= '0;
                sec_q[d] <= '0;
            end else if (we_i && addr_i == DIG_W'(d)) begin
                if (sel_i) sec_q[d] <= wdata_i;
                else       pri_q[d] <= wdata_i;
            end
        end
    end

    always_comb begin
        pri_row_o = '0;
        sec_row_o = '0;
        any_set   = 1'b0;
        for (int d = 0; d < NUM_DIGITS; d++) begin
            if (rd_addr_i == DIG_W'(d)) begin
                pri_row_o = pri_q[d];
                sec_row_o = sec_q[d];
            end
            any_set = any_set | (|pri_q[d]) | (|sec_q[d]);
        end
    end

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !any_set);
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_i && we_i) |=> !any_set);
endmodule

// File: rtl/blink_plane_ctrl.sv
module blink_plane_ctrl
    import blink_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int SEGS       = 8,
    parameter int HALF_TICKS = 8,
    parameter int DIG_W      = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             cfg_we_i,
    input  logic [7:0]       cfg_wdata_i,
    output logic [7:0]       cfg_rdata_o,
    input  logic             pl_we_i,
    input  logic             pl_sel_i,
    input  logic [DIG_W-1:0] pl_addr_i,
    input  logic [SEGS-1:0]  pl_wdata_i,
    output logic [SEGS-1:0]  seg_o,
    output logic [DIG_W-1:0] digit_o
);
    cfg_t            cfg_q;
    phase_e          phase;
    logic            resync;
    logic            clr;
    logic [SEGS-1:0] pri_row;
    logic [SEGS-1:0] sec_row;
    logic            unused_bits;

    assign resync      = cfg_we_i && cfg_wdata_i[CFG_BIT_SYNC];
    assign clr         = cfg_we_i && cfg_wdata_i[CFG_BIT_CLR];
    assign unused_bits = ^{cfg_wdata_i[7], cfg_wdata_i[6], cfg_wdata_i[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we_i) begin
            cfg_q.en    <= cfg_wdata_i[CFG_BIT_EN];
            cfg_q.b_bit <= cfg_wdata_i[CFG_BIT_B];
            cfg_q.s_bit <= cfg_wdata_i[CFG_BIT_S];
        end
    end

    always_comb begin
        cfg_rdata_o                = '0;
        cfg_rdata_o[CFG_BIT_PHASE] = (phase == PH_FIRST);
        cfg_rdata_o[CFG_BIT_EN]    = cfg_q.en;
        cfg_rdata_o[CFG_BIT_B]     = cfg_q.b_bit;
        cfg_rdata_o[CFG_BIT_S]     = cfg_q.s_bit;
    end

    blink_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
        .clk(clk), .rst(rst), .tick_i(tick_i), .resync_i(resync), .phase_o(phase)
    );

    scan_counter #(.NUM_DIGITS(NUM_DIGITS), .DIG_W(DIG_W)) u_scan (
        .clk(clk), .rst(rst), .tick_i(tick_i), .resync_i(resync), .digit_o(digit_o)
    );

    plane_store #(.NUM_DIGITS(NUM_DIGITS), .SEGS(SEGS), .DIG_W(DIG_W)) u_planes (
        .clk(clk), .rst(rst), .clr_i(clr), .we_i(pl_we_i), .sel_i(pl_sel_i),
        .addr_i(pl_addr_i), .wdata_i(pl_wdata_i), .rd_addr_i(digit_o),
        .pri_row_o(pri_row), .sec_row_o(sec_row)
    );

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        assign seg_o[s] = seg_bit(sec_row[s], pri_row[s], cfg_q.en, phase);
    end

    p_oneshot_rb_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata_o[CFG_BIT_SYNC] == 1'b0 && cfg_rdata_o[CFG_BIT_CLR] == 1'b0);
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_we_i |=> $stable(cfg_q));
endmodule

// File: tb/blink_plane_ctrl_tb.sv
module blink_plane_ctrl_tb;
    localparam int ND = 4;
    localparam int SG = 8;
    localparam int HT = 8;
    localparam int DW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_i = 1'b0;
    logic          cfg_we_i = 1'b0;
    logic [7:0]    cfg_wdata_i = '0;
    logic [7:0]    cfg_rdata_o;
    logic          pl_we_i = 1'b0;
    logic          pl_sel_i = 1'b0;
    logic [DW-1:0] pl_addr_i = '0;
    logic [SG-1:0] pl_wdata_i = '0;
    logic [SG-1:0] seg_o;
    logic [DW-1:0] digit_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [SG-1:0] m_p0 [ND];
    logic [SG-1:0] m_p1 [ND];
    logic m_e, m_b, m_s, m_ph;
    int   m_cnt, m_scan;

    always #10 clk = ~clk;

    blink_plane_ctrl #(.NUM_DIGITS(ND), .SEGS(SG), .HALF_TICKS(HT)) u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cfg_we_i(cfg_we_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .pl_we_i(pl_we_i),
        .pl_sel_i(pl_sel_i), .pl_addr_i(pl_addr_i), .pl_wdata_i(pl_wdata_i),
        .seg_o(seg_o), .digit_o(digit_o)
    );

    function automatic logic [SG-1:0] exp_seg();
        logic [SG-1:0] r;
        for (int i = 0; i < SG; i++) begin
            if (!m_e) r[i] = m_p0[m_scan][i];
            else case ({m_p1[m_scan][i], m_p0[m_scan][i]})
                2'b00:   r[i] = 1'b0;
                2'b01:   r[i] = !m_ph;
                2'b10:   r[i] = m_ph;
                default: r[i] = 1'b1;
            endcase
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_rd();
        return {~m_ph, 3'b000, m_e, m_b, 1'b0, m_s};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int d = 0; d < ND; d++) begin m_p0[d] = '0; m_p1[d] = '0; end
        m_e = 0; m_b = 0; m_s = 0; m_ph = 0; m_cnt = 0; m_scan = 0;
    endtask

    task automatic check_all(input string seg_tag);
        chk(seg_tag, 32'(seg_o), 32'(exp_seg()));
        chk("R8 digit", 32'(digit_o), 32'(m_scan));
        chk("R4 readback", 32'(cfg_rdata_o), 32'(exp_rd()));
    endtask

    // one clock cycle; called at a negedge
    task automatic cyc(input logic tk, input logic cw, input logic [7:0] cd,
                       input logic pw, input logic ps, input int pa,
                       input logic [SG-1:0] pd, input string seg_tag);
        tick_i = tk; cfg_we_i = cw; cfg_wdata_i = cd;
        pl_we_i = pw; pl_sel_i = ps; pl_addr_i = DW'(pa); pl_wdata_i = pd;
        @(posedge clk);
        if (cw) begin m_e = cd[3]; m_b = cd[2]; m_s = cd[0]; end
        if (cw && cd[4]) begin
            m_cnt = 0; m_ph = 0; m_scan = 0;
        end else if (tk) begin
            if (m_cnt == HT - 1) begin m_cnt = 0; m_ph = ~m_ph; end
            else m_cnt++;
            m_scan = (m_scan == ND - 1) ? 0 : m_scan + 1;
        end
        if (cw && cd[5]) begin
            for (int d = 0; d < ND; d++) begin m_p0[d] = '0; m_p1[d] = '0; end
        end else if (pw) begin
            if (ps) m_p1[pa] = pd; else m_p0[pa] = pd;
        end
        @(negedge clk);
        tick_i = 0; cfg_we_i = 0; pl_we_i = 0;
        check_all(seg_tag);
    endtask

    task automatic idle_tick(input string tag);
        cyc(1, 0, 8'h00, 0, 0, 0, '0, tag);
    endtask

    task automatic wr_plane(input logic ps, input int pa, input logic [SG-1:0] pd);
        cyc(0, 0, 8'h00, 1, ps, pa, pd, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] cd;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 seg", 32'(seg_o), 32'h0);
        chk("R1 digit", 32'(digit_o), 32'h0);
        chk("R1 rdata", 32'(cfg_rdata_o), 32'h80);

        // R10 / R2: secondary plane ignored when blink off
        for (int d = 0; d < ND; d++) begin
            wr_plane(0, d, SG'(8'h11 << d));
            wr_plane(1, d, 8'hFF);
        end
        for (int k = 0; k < 2 * HT; k++) idle_tick("R2");

        // R3: every pair on its own segment, both halves
        wr_plane(0, 0, 8'b1010_1010);
        wr_plane(1, 0, 8'b1100_1100);
        cyc(0, 1, 8'h18, 0, 0, 0, '0, "R3");
        for (int k = 0; k < 3 * HT; k++) idle_tick("R3");

        // R9: B and S stored, no seg effect; D6, D1 not stored
        cyc(0, 1, 8'h4F, 0, 0, 0, '0, "R9");
        chk("R9 rdata", 32'(cfg_rdata_o & 8'h7F), 32'h0D);
        for (int k = 0; k < 2; k++) idle_tick("R9");

        // R5: resync with a tick in the same cycle; one-shot bit reads 0
        for (int k = 0; k < 5; k++) idle_tick("R3");
        cyc(1, 1, 8'h18, 0, 0, 0, '0, "R5");
        chk("R5 digit zero", 32'(digit_o), 32'h0);
        chk("R5 T reads 0", 32'(cfg_rdata_o[4]), 32'h0);

        // R7: clear with same-cycle plane write; R6 clears all
        cyc(0, 1, 8'h28, 1, 1, 2, 8'hFF, "R7");
        chk("R6 R reads 0", 32'(cfg_rdata_o[5]), 32'h0);
        for (int k = 0; k < ND; k++) idle_tick("R7");
        // R6 with R=0 leaves planes
        wr_plane(0, 1, 8'h5A);
        cyc(0, 1, 8'h08, 0, 0, 0, '0, "R6");
        for (int k = 0; k < ND; k++) idle_tick("R6");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            cd = 8'($urandom);
            if (($urandom % 4) != 0) cd[4] = 0;
            if (($urandom % 6) != 0) cd[5] = 0;
            cyc(1'($urandom % 2), (($urandom % 12) == 0), cd,
                1'($urandom % 2), 1'($urandom % 2), int'($urandom % ND),
                SG'($urandom), m_e ? "R3" : "R2");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule